// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Sequencing

This block produces all of the refresh activity that an asynchronous DRAM with 1024 rows needs. After reset it waits out the power-up pause. It then runs a fixed burst of CAS-before-RAS warm-up cycles and only after that reports the memory as ready. From then on an interval timer adds one owed refresh per period, and the block collects the owed refreshes in a small saturating counter.

The block talks to the access controller through a request/grant pair. It raises its request whenever it has work and waits for the grant. While the grant is held it drives the row strobe, both column strobes and the write strobe itself. Owed refreshes that piled up while the bus was busy are run back to back under one grant.

A mode input picks between CAS-before-RAS refresh and RAS-only refresh. In RAS-only refresh the row comes from an internal wrapping row counter. A self-refresh input lets the controller park the memory in self-refresh. The block holds it there for a minimum time and, on exit, guarantees a long precharge before any new cycle.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `ref_req` stays low and every strobe stays high for `PWRUP_CYC` cycles.
- R2: The power-up pause is followed by `WARMUP_CNT` CAS-before-RAS cycles, whatever `mode_ras_only` says. `init_done` rises only when the last of them has finished its precharge.
- R3: In a CAS-before-RAS cycle both column strobes fall together `CAS_LEAD_CYC` cycles before the row strobe falls. They stay low for as long as the row strobe is low.
- R4: Every refresh cycle keeps the row strobe low for `RAS_LOW_CYC` cycles and then high, with the column strobes high, for at least `RAS_PRE_CYC` cycles.
- R5: With `mode_ras_only` = 1 (after warm-up), each refresh is a row-strobe pulse with both column strobes high for the whole cycle. `row_addr` shows the internal row counter, which steps by one after each such cycle and wraps from 1023 to 0.
- R6: Once `init_done` is high, one refresh is owed every `INTERVAL_CYC` cycles. At most `MAX_PEND` owed refreshes are kept, and periods beyond that are lost.
- R7: Owed refreshes are serviced back to back while the grant is held, with `ref_req` staying high between them.
- R8: No strobe falls unless `ref_gnt` was high in the previous cycle. While `ref_req` is low, all strobes stay high.
- R9: With `self_req` high, `init_done` high and nothing owed, the block enters self-refresh. It leads with the column strobes, then holds both strobes low with `self_active` high for at least `SELF_MIN_CYC` cycles and until `self_req` is low.
- R10: Leaving self-refresh holds the row strobe high for `SELF_PRE_CYC` cycles. It also discards owed refreshes and restarts the interval, so the next refresh comes no sooner than `INTERVAL_CYC` cycles later.
- R11: An interval tick that lands in the same cycle as the start of a refresh is counted, so that refresh is not lost.
- R12: `we_n` stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Grant of the memory bus from the access controller |
| mode_ras_only | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS refresh |
| self_req | input | 1 | Request to enter and stay in self-refresh |
| ref_req | output | 1 | Request for the memory bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_l_n | output | 1 | Lower-lane column strobe, active low |
| cas_u_n | output | 1 | Upper-lane column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | ROW_BITS | Row counter used for RAS-only refresh |
| init_done | output | 1 | Power-up and warm-up finished |
| self_active | output | 1 | Memory held in self-refresh |

## Verification
The interval tick and the start of a refresh can both change the owed count in the same cycle, one adding and one taking. The bench provokes this by keeping the grant low for a series of lengths that differ by single cycles and then releasing it. This slides the back-to-back burst across the tick phase. Each burst is judged by counting row-strobe falls between grant and request drop, against bounds derived from `MAX_PEND`, while a behavioural model checks every output on every cycle.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [3:0] {
        PH_PWRUP,
        PH_IDLE,
        PH_REQ,
        PH_CAS_LEAD,
        PH_CBR_RAS,
        PH_ROW_RAS,
        PH_PRECH,
        PH_SELF_CAS,
        PH_SELF_HOLD,
        PH_SELF_PRE
    } phase_e;

    function automatic int max_of2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_rfsh_pending.sv
module dram_rfsh_pending #(
    parameter int INTERVAL_CYC = 1560,
    parameter int MAX_PEND     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic take,
    input  logic clear,
    output logic has_pend
);
    localparam int IW = $clog2(INTERVAL_CYC);
    localparam int PW = $clog2(MAX_PEND + 1);

    typedef struct packed {
        logic [IW-1:0] ival;
        logic [PW-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;
    logic  tick;
    logic [PW-1:0] after_take;

    always_comb begin
        st_d       = st_q;
        tick       = run && (st_q.ival == IW'(INTERVAL_CYC - 1));
        after_take = st_q.pend;
        if (run) begin
            st_d.ival = tick ? '0 : st_q.ival + 1'b1;
        end
        if (take && (st_q.pend != '0)) begin
            after_take = st_q.pend - 1'b1;
        end
        st_d.pend = after_take;
        // R11: a tick coinciding with a take still adds one
        if (tick && (after_take != PW'(MAX_PEND))) begin
            st_d.pend = after_take + 1'b1;
        end
        if (clear) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign has_pend = (st_q.pend != '0);

endmodule

// File: rtl/dram_rfsh_rowctr.sv
module dram_rfsh_rowctr #(
    parameter int ROW_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    output logic [ROW_BITS-1:0] row
);
    logic [ROW_BITS-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (adv) row_d = row_q + 1'b1;   // wraps at the top row
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_rfsh_pkg::*;
#(
    parameter int PWRUP_CYC    = 10000,
    parameter int WARMUP_CNT   = 8,
    parameter int INTERVAL_CYC = 1560,
    parameter int MAX_PEND     = 8,
    parameter int CAS_LEAD_CYC = 1,
    parameter int RAS_LOW_CYC  = 5,
    parameter int RAS_PRE_CYC  = 3,
    parameter int SELF_MIN_CYC = 10000,
    parameter int SELF_PRE_CYC = 9,
    parameter int ROW_BITS     = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_gnt,
    input  logic                mode_ras_only,
    input  logic                self_req,
    output logic                ref_req,
    output logic                ras_n,
    output logic                cas_l_n,
    output logic                cas_u_n,
    output logic                we_n,
    output logic [ROW_BITS-1:0] row_addr,
    output logic                init_done,
    output logic                self_active
);
    localparam int TMAX = max_of2(max_of2(PWRUP_CYC, SELF_MIN_CYC),
                                  max_of2(max_of2(RAS_LOW_CYC, RAS_PRE_CYC),
                                          max_of2(CAS_LEAD_CYC, SELF_PRE_CYC)));
    localparam int TW = $clog2(TMAX + 1);
    localparam int WW = $clog2(WARMUP_CNT + 1);

    typedef struct packed {
        phase_e        ph;
        logic [TW-1:0] tmr;
        logic [WW-1:0] warm;
        logic          init;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    logic   has_pend, take, clr, adv, run;
    logic   do_ref, do_self, work, go, finish, tmr_done;
    phase_e launch_ph;
    logic [TW-1:0] launch_tmr;
    logic   in_self;

    assign in_self = (ctl_q.ph == PH_SELF_CAS) || (ctl_q.ph == PH_SELF_HOLD) ||
                     (ctl_q.ph == PH_SELF_PRE);
    assign run = ctl_q.init && !in_self;

    dram_rfsh_pending #(
        .INTERVAL_CYC(INTERVAL_CYC),
        .MAX_PEND    (MAX_PEND)
    ) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .take    (take),
        .clear   (clr),
        .has_pend(has_pend)
    );

    dram_rfsh_rowctr #(
        .ROW_BITS(ROW_BITS)
    ) u_row (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .row  (row_addr)
    );

    always_comb begin
        ctl_d    = ctl_q;
        take     = 1'b0;
        clr      = 1'b0;
        adv      = 1'b0;
        go       = 1'b0;
        finish   = 1'b0;
        tmr_done = (ctl_q.tmr == '0);
        do_ref   = (ctl_q.warm != '0) || has_pend;
        do_self  = self_req && ctl_q.init && !do_ref;
        work     = do_ref || do_self;

        // warm-up cycles are always CAS-before-RAS
        if (do_ref && (ctl_q.warm == '0) && mode_ras_only) begin
            launch_ph  = PH_ROW_RAS;
            launch_tmr = TW'(RAS_LOW_CYC - 1);
        end else if (do_ref) begin
            launch_ph  = PH_CAS_LEAD;
            launch_tmr = TW'(CAS_LEAD_CYC - 1);
        end else begin
            launch_ph  = PH_SELF_CAS;
            launch_tmr = TW'(CAS_LEAD_CYC - 1);
        end

        unique case (ctl_q.ph)
            PH_PWRUP: begin
                if (tmr_done) ctl_d.ph = PH_REQ;
                else          ctl_d.tmr = ctl_q.tmr - 1'b1;
            end
            PH_IDLE: begin
                if (work) ctl_d.ph = PH_REQ;
            end
            PH_REQ: begin
                if (!work)        ctl_d.ph = PH_IDLE;
                else if (ref_gnt) go = 1'b1;
            end
            PH_CAS_LEAD: begin
                if (tmr_done) begin
                    ctl_d.ph  = PH_CBR_RAS;
                    ctl_d.tmr = TW'(RAS_LOW_CYC - 1);
                end else ctl_d.tmr = ctl_q.tmr - 1'b1;
            end
            PH_CBR_RAS, PH_ROW_RAS: begin
                if (tmr_done) begin
                    ctl_d.ph  = PH_PRECH;
                    ctl_d.tmr = TW'(RAS_PRE_CYC - 1);
                    adv       = (ctl_q.ph == PH_ROW_RAS);
                end else ctl_d.tmr = ctl_q.tmr - 1'b1;
            end
            PH_SELF_CAS: begin
                if (tmr_done) begin
                    ctl_d.ph  = PH_SELF_HOLD;
                    ctl_d.tmr = TW'(SELF_MIN_CYC - 1);
                end else ctl_d.tmr = ctl_q.tmr - 1'b1;
            end
            PH_SELF_HOLD: begin
                if (!tmr_done) ctl_d.tmr = ctl_q.tmr - 1'b1;
                else if (!self_req) begin
                    ctl_d.ph  = PH_SELF_PRE;
                    ctl_d.tmr = TW'(SELF_PRE_CYC - 1);
                end
            end
            PH_PRECH, PH_SELF_PRE: begin
                if (tmr_done) finish = 1'b1;
                else          ctl_d.tmr = ctl_q.tmr - 1'b1;
            end
            default: ctl_d.ph = PH_IDLE;
        endcase

        if (finish) begin
            if (ctl_q.warm == '0) ctl_d.init = 1'b1;
            if (work && ref_gnt) go = 1'b1;
            else if (work)       ctl_d.ph = PH_REQ;
            else                 ctl_d.ph = PH_IDLE;
        end

        if (go) begin
            ctl_d.ph  = launch_ph;
            ctl_d.tmr = launch_tmr;
            if (do_ref) begin
                if (ctl_q.warm != '0) ctl_d.warm = ctl_q.warm - 1'b1;
                else                  take = 1'b1;
            end else begin
                clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.ph   <= PH_PWRUP;
            ctl_q.tmr  <= TW'(PWRUP_CYC - 1);
            ctl_q.warm <= WW'(WARMUP_CNT);
            ctl_q.init <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ref_req     = (ctl_q.ph != PH_PWRUP) && (ctl_q.ph != PH_IDLE);
    assign ras_n       = !((ctl_q.ph == PH_CBR_RAS) || (ctl_q.ph == PH_ROW_RAS) ||
                           (ctl_q.ph == PH_SELF_HOLD));
    assign cas_l_n     = !((ctl_q.ph == PH_CAS_LEAD) || (ctl_q.ph == PH_CBR_RAS) ||
                           (ctl_q.ph == PH_SELF_CAS) || (ctl_q.ph == PH_SELF_HOLD));
    assign cas_u_n     = cas_l_n;
    assign we_n        = 1'b1;
    assign init_done   = ctl_q.init;
    assign self_active = (ctl_q.ph == PH_SELF_HOLD);

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter int RAS_LOW_CYC = 5,
    parameter int RAS_PRE_CYC = 3,
    parameter int PWRUP_CYC   = 10000
) (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic ref_req,
    input logic ras_n,
    input logic cas_l_n,
    input logic cas_u_n,
    input logic self_active
);
    int unsigned lo_cnt, hi_cnt, since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt    <= 0;
            hi_cnt    <= 0;
            since_rst <= 0;
        end else begin
            lo_cnt    <= ras_n ? 0 : ((lo_cnt == 32'hFFFF_FFFF) ? lo_cnt : lo_cnt + 1);
            hi_cnt    <= !ras_n ? 0 : ((hi_cnt == 32'hFFFF_FFFF) ? hi_cnt : hi_cnt + 1);
            since_rst <= (since_rst >= PWRUP_CYC) ? since_rst : since_rst + 1;
        end
    end

    // R1
    p_quiet_pwrup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < PWRUP_CYC) |-> !ref_req && ras_n && cas_l_n);

    p_lanes_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cas_l_n == cas_u_n);

    p_cas_leads_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_l_n) |-> $past(!cas_l_n));

    p_ras_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (lo_cnt >= RAS_LOW_CYC));

    p_ras_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= RAS_PRE_CYC));

    p_cas_quiet_in_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n) && $past(cas_l_n)) |-> cas_l_n);

    p_start_needs_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_l_n) || ($fell(ras_n) && cas_l_n)) |-> $past(ref_gnt));

    p_idle_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req |-> (ras_n && cas_l_n && cas_u_n));

    p_self_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        self_active |-> (!ras_n && !cas_l_n && ref_req));

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .RAS_PRE_CYC(RAS_PRE_CYC),
    .PWRUP_CYC  (PWRUP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .ras_n      (ras_n),
    .cas_l_n    (cas_l_n),
    .cas_u_n    (cas_u_n),
    .self_active(self_active)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int PWR   = 20;
    localparam int WARM  = 8;
    localparam int INTV  = 40;
    localparam int MAXP  = 8;
    localparam int LEAD  = 1;
    localparam int LOW   = 3;
    localparam int PRE   = 2;
    localparam int SMIN  = 10;
    localparam int SPRE  = 3;
    localparam int RB    = 10;
    localparam int CYC_LEN = LEAD + LOW + PRE;

    localparam int M_PWR = 0, M_IDLE = 1, M_REQ = 2, M_LEAD = 3, M_CBR = 4,
                   M_ROW = 5, M_PRE = 6, M_SCAS = 7, M_SHOLD = 8, M_SPRE = 9;

    logic clk = 0, rst_n = 0;
    logic ref_gnt = 0, mode_ras_only = 1, self_req = 0;
    logic ref_req, ras_n, cas_l_n, cas_u_n, we_n, init_done, self_active;
    logic [RB-1:0] row_addr;
    logic auto_g = 0, man_g = 0;

    int vectors = 0, errors = 0, cycles = 0;
    int ras_falls = 0, warm_cbr = 0, warm_row = 0;
    logic prev_ras = 1;
    int prev_row = 0;
    bit saw_wrap = 0;
    string cur_tag = "R1";

    // behavioural reference state
    int m_ph, m_tmr, m_warm, m_init, m_ival, m_pend, m_row;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_sched #(
        .PWRUP_CYC(PWR), .WARMUP_CNT(WARM), .INTERVAL_CYC(INTV), .MAX_PEND(MAXP),
        .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(LOW), .RAS_PRE_CYC(PRE),
        .SELF_MIN_CYC(SMIN), .SELF_PRE_CYC(SPRE), .ROW_BITS(RB)
    ) i_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .mode_ras_only(mode_ras_only),
        .self_req(self_req), .ref_req(ref_req), .ras_n(ras_n), .cas_l_n(cas_l_n),
        .cas_u_n(cas_u_n), .we_n(we_n), .row_addr(row_addr), .init_done(init_done),
        .self_active(self_active)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    function automatic string ph_tag(int ph);
        case (ph)
            M_PWR:          return "R1";
            M_LEAD, M_CBR:  return "R3";
            M_ROW:          return "R5";
            M_PRE:          return "R4";
            M_SCAS, M_SHOLD:return "R9";
            M_SPRE:         return "R10";
            default:        return "R8";
        endcase
    endfunction

    // reference model: advances on each rising edge from the inputs then present
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = M_PWR; m_tmr = PWR - 1; m_warm = WARM; m_init = 0;
            m_ival = 0; m_pend = 0; m_row = 0;
        end else begin
            automatic bit dref  = (m_warm > 0) || (m_pend > 0);
            automatic bit dself = self_req && (m_init != 0) && !dref;
            automatic bit wk    = dref || dself;
            automatic bit slf   = (m_ph == M_SCAS) || (m_ph == M_SHOLD) || (m_ph == M_SPRE);
            automatic bit runi  = (m_init != 0) && !slf;
            automatic bit tick  = runi && (m_ival == INTV - 1);
            automatic bit start = 0, done_pre = 0, take = 0, clr = 0;
            automatic int nph = m_ph, ntmr = m_tmr, nwarm = m_warm, ninit = m_init;
            case (m_ph)
                M_PWR:  if (m_tmr == 0) nph = M_REQ; else ntmr = m_tmr - 1;
                M_IDLE: if (wk) nph = M_REQ;
                M_REQ:  if (!wk) nph = M_IDLE; else if (ref_gnt) start = 1;
                M_LEAD: if (m_tmr == 0) begin nph = M_CBR; ntmr = LOW - 1; end else ntmr = m_tmr - 1;
                M_CBR, M_ROW: if (m_tmr == 0) begin
                        nph = M_PRE; ntmr = PRE - 1;
                        if (m_ph == M_ROW) m_row = (m_row + 1) % (1 << RB);
                    end else ntmr = m_tmr - 1;
                M_SCAS: if (m_tmr == 0) begin nph = M_SHOLD; ntmr = SMIN - 1; end else ntmr = m_tmr - 1;
                M_SHOLD: if (m_tmr != 0) ntmr = m_tmr - 1;
                         else if (!self_req) begin nph = M_SPRE; ntmr = SPRE - 1; end
                default: if (m_tmr == 0) done_pre = 1; else ntmr = m_tmr - 1;
            endcase
            if (done_pre) begin
                if (m_warm == 0) ninit = 1;
                if (wk && ref_gnt) start = 1; else if (wk) nph = M_REQ; else nph = M_IDLE;
            end
            if (start) begin
                if (dref) begin
                    if (m_warm == 0 && mode_ras_only) begin nph = M_ROW; ntmr = LOW - 1; end
                    else begin nph = M_LEAD; ntmr = LEAD - 1; end
                    if (m_warm > 0) nwarm = m_warm - 1; else take = 1;
                end else begin
                    nph = M_SCAS; ntmr = LEAD - 1; clr = 1;
                end
            end
            if (clr) begin
                m_pend = 0; m_ival = 0;
            end else begin
                if (runi) m_ival = tick ? 0 : m_ival + 1;
                if (take && m_pend > 0) m_pend = m_pend - 1;
                if (tick && m_pend < MAXP) m_pend = m_pend + 1;
            end
            m_ph = nph; m_tmr = ntmr; m_warm = nwarm; m_init = ninit;
        end
    end

    // grant driven by the bench controller on the falling edge
    always @(negedge clk) ref_gnt <= auto_g ? ref_req : man_g;

    // per-cycle comparison and observation, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            automatic string tg = ph_tag(m_ph);
            chk(tg, "ras_n", ras_n, !(m_ph == M_CBR || m_ph == M_ROW || m_ph == M_SHOLD));
            chk(tg, "cas_l_n", cas_l_n, !(m_ph == M_LEAD || m_ph == M_CBR || m_ph == M_SCAS || m_ph == M_SHOLD));
            chk("R3", "cas_u_n", cas_u_n, !(m_ph == M_LEAD || m_ph == M_CBR || m_ph == M_SCAS || m_ph == M_SHOLD));
            chk(cur_tag, "ref_req", ref_req, (m_ph != M_PWR && m_ph != M_IDLE));
            chk("R12", "we_n", we_n, 1);
            chk("R5", "row_addr", row_addr, m_row);
            chk("R2", "init_done", init_done, m_init);
            chk("R9", "self_active", self_active, m_ph == M_SHOLD);
            if (prev_ras && !ras_n) begin
                ras_falls++;
                if (!init_done) begin
                    if (cas_l_n) warm_row++; else warm_cbr++;
                end
            end
            if (prev_row == (1 << RB) - 1 && row_addr == 0) saw_wrap = 1;
            prev_ras = ras_n;
            prev_row = row_addr;
        end
        if (cycles > 190000) begin
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // hold the grant off, then release it and measure the catch-up burst (R6, R7, R11)
    task automatic burst(input int hold, input string tag);
        automatic int f0, hi = 0, nf;
        auto_g = 0; man_g = 0;
        repeat (hold) @(negedge clk);
        f0 = ras_falls;
        auto_g = 1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (ref_req) hi++; else break;
        end
        nf = ras_falls - f0;
        chk(tag, "burst in range", (nf >= MAXP && nf <= MAXP + 2), 1);
        // R7: no gap between serviced refreshes
        chk("R7", "burst without gaps", (hi <= nf * CYC_LEN + 3), 1);
    endtask

    initial begin
        automatic int n, gap;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_tag = "R1";
        repeat (PWR) @(negedge clk);
        // R8: request waits for the grant
        cur_tag = "R8";
        repeat (12) @(negedge clk);
        chk("R8", "strobes idle without grant", ras_n && cas_l_n, 1);
        // R2: warm-up is CAS-before-RAS even with the row mode selected
        cur_tag = "R2";
        auto_g = 1;
        repeat (WARM * (CYC_LEN + 2) + 10) @(negedge clk);
        chk("R2", "init_done after warm-up", init_done, 1);
        chk("R2", "warm-up CBR count", warm_cbr, WARM);
        chk("R2", "warm-up row-only count", warm_row, 0);
        mode_ras_only = 0; cur_tag = "R3";
        repeat (300) @(negedge clk);
        mode_ras_only = 1; cur_tag = "R5";
        repeat (300) @(negedge clk);
        mode_ras_only = 0; cur_tag = "R6";
        burst(600, "R6");
        cur_tag = "R11";
        for (int off = 0; off < CYC_LEN; off++) burst(400 + off, "R11");
        // R9: short self-refresh request still gets the minimum hold
        cur_tag = "R9";
        self_req = 1;
        for (int i = 0; i < 400 && !self_active; i++) @(negedge clk);
        self_req = 0;
        n = 0;
        for (int i = 0; i < 400 && self_active; i++) begin n++; @(negedge clk); end
        chk("R9", "minimum self hold", n, SMIN);
        // R9/R10: long self-refresh and exit spacing
        repeat (20) @(negedge clk);
        self_req = 1;
        for (int i = 0; i < 400 && !self_active; i++) @(negedge clk);
        repeat (60) @(negedge clk);
        chk("R9", "self held while requested", self_active, 1);
        cur_tag = "R10";
        self_req = 0;
        for (int i = 0; i < 400 && self_active; i++) @(negedge clk);
        n = ras_falls; gap = 0;
        for (int i = 0; i < 400 && ras_falls == n; i++) begin gap++; @(negedge clk); end
        chk("R10", "quiet after self exit", (gap >= INTV), 1);
        // R5: row counter wraps
        mode_ras_only = 1; cur_tag = "R5";
        for (int i = 0; i < 45000 && !saw_wrap; i++) @(negedge clk);
        chk("R5", "row counter wrapped", saw_wrap, 1);
        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule